// File: doc/BRIEF.md
# Prescaled Duty-Cycle Pulse Generator

This block drives one output pin with a pulse-width-modulated waveform. A prescaler divides the incoming clock by a power of two chosen by a divide-select input `m`. The divided rate steps a 256-position duty counter. The output is high for the first `n` positions of every 256-position window, where `n` is the 8-bit duty input. This gives a waveform of frequency `f_clk / (2^m * 256)` with duty `n/256`.

Two control bits let the pin act as a plain level instead. A force-high bit holds the output at 1 whatever the enable says. With force-high clear and enable clear, the output sits at 0. A power-save input shuts the modulation circuitry down: the output drops low unless force-high is set, and the counters are cleared.

Duty and divide values are captured into shadow registers only while the circuitry is idle or at the end of a full window. A value changed mid-window therefore never produces a truncated or stretched pulse.

A small mode machine chooses what drives the pin. It has three states:
- `MODE_LOW`: output held at 0.
- `MODE_HIGH`: output held at 1.
- `MODE_RUN`: the comparator drives the output.

The machine takes its transitions on every clock, and all of them are evaluated in the same priority:
- **to_high**: force-high is set. This is taken from any state.
- **to_run**: force-high is clear, enable is set and power-save is clear.
- **to_low**: every other case.

Top module: `duty_pwm`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pwm_out` is 0 and the mode is `MODE_LOW`.
- R2: When `force_hi` is 1 at a rising clock edge, the mode becomes `MODE_HIGH` and `pwm_out` is 1 during the following cycle, regardless of `pwm_en` and `pwr_save`.
- R3: When `force_hi` is 0 and `pwm_en` is 0 at a rising edge, the mode becomes `MODE_LOW` and `pwm_out` is 0 during the following cycle.
- R4: When `force_hi` is 0 and `pwr_save` is 1 at a rising edge, the modulation circuitry is disabled and `pwm_out` is 0 during the following cycle, even with `pwm_en` at 1.
- R5: In `MODE_RUN` each duty-counter position lasts exactly `2^m` clock cycles, so one window lasts `256 * 2^m` cycles.
- R6: In `MODE_RUN`, `pwm_out` is 1 while the duty-counter position is below the captured duty `n`, and 0 otherwise, so it is high for `n * 2^m` cycles per window.
- R7: With a captured duty of 0, `pwm_out` stays 0 for every cycle of the window. With 255, it is low only during the last position of the window.
- R8: Changes to `duty` or `div_sel` made while running take effect only at the start of the next window. The current window completes with the old values.
- R9: On entry to `MODE_RUN` from either other mode, the prescaler and duty counter start at 0. A fresh window starts, using the `duty` and `div_sel` present at the entering edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock source being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | DIV_W (4) | Divide-select `m`; prescaler divides by `2^m` |
| duty | input | DUTY_W (8) | Duty value `n`; high share is `n/256` |
| pwm_en | input | 1 | Enables the modulation circuitry |
| force_hi | input | 1 | Holds the output at 1; overrides all else |
| pwr_save | input | 1 | Power-save request; disables the modulation circuitry |
| pwm_out | output | 1 | Modulated or forced output level |

## Verification
The hardest situation to reach is a duty or divide change landing partway through a running window. The captured value must then be seen to remain in force until the exact boundary cycle, and the new value must take over from there. The stimulus first changes `duty` and `div_sel` while a window is part-way through. It then keeps the circuitry running across two complete windows, so the last high cycles under the old values and the first cycles under the new ones are both compared. Disable and power-save pulses are also placed mid-window. This shows that the restart begins a fresh window rather than continuing the interrupted one.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        MODE_LOW  = 2'd0,
        MODE_HIGH = 2'd1,
        MODE_RUN  = 2'd2
    } pwm_mode_e;

endpackage

// File: rtl/pwm_mode_fsm.sv
module pwm_mode_fsm
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      force_hi,
    input  logic      pwm_en,
    input  logic      pwr_save,
    output pwm_mode_e mode_q,
    output logic      run
);

    pwm_mode_e mode_d;
    logic      want_run;

    assign want_run = pwm_en && !pwr_save;

    // next-state selection; every state evaluates the same priority
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_LOW: begin
                if (force_hi)      mode_d = MODE_HIGH;   // to_high
                else if (want_run) mode_d = MODE_RUN;    // to_run
                else               mode_d = MODE_LOW;
            end
            MODE_HIGH: begin
                if (force_hi)      mode_d = MODE_HIGH;
                else if (want_run) mode_d = MODE_RUN;    // to_run
                else               mode_d = MODE_LOW;    // to_low
            end
            MODE_RUN: begin
                if (force_hi)      mode_d = MODE_HIGH;   // to_high
                else if (want_run) mode_d = MODE_RUN;
                else               mode_d = MODE_LOW;    // to_low
            end
            default:               mode_d = MODE_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_LOW;
        else        mode_q <= mode_d;
    end

    // outputs of the machine
    always_comb begin
        unique case (mode_q)
            MODE_RUN: run = 1'b1;
            default:  run = 1'b0;
        endcase
    end

    // R1: the mode register leaves reset in MODE_LOW
    assert_reset_low_R1: assert property (@(posedge clk)
        (!$past(rst_n) && rst_n) |-> (mode_q == MODE_LOW));

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_l,
    output logic             tick
);

    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] limit;

    // terminal count is 2^m - 1
    assign limit = ~({PRE_W{1'b1}} << div_l);
    assign tick  = run && (pcnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pcnt <= '0;
        else if (!run) pcnt <= '0;
        else if (tick) pcnt <= '0;
        else           pcnt <= pcnt + 1'b1;
    end

    // R5: prescaler restarts after each tick
    assert_tick_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (pcnt == '0));

    // R5: between ticks the prescaler advances by one each cycle
    assert_pre_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (pcnt == $past(pcnt) + 1'b1));

    // R9: idle circuitry leaves the prescaler cleared
    assert_pre_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pcnt == '0));

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int DIV_W  = 4,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic [DIV_W-1:0]  div_in,
    output logic [DIV_W-1:0]  div_l,
    output logic              above
);

    localparam logic [DUTY_W-1:0] POS_LAST = {DUTY_W{1'b1}};

    logic [DUTY_W-1:0] dcnt;
    logic [DUTY_W-1:0] duty_l;
    logic              wrap;
    logic              capture;

    assign wrap    = tick && (dcnt == POS_LAST);
    assign capture = !run || wrap;
    assign above   = dcnt < duty_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    dcnt <= '0;
        else if (!run) dcnt <= '0;
        else if (tick) dcnt <= dcnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_l <= '0;
            div_l  <= '0;
        end else if (capture) begin
            duty_l <= duty_in;
            div_l  <= div_in;
        end
    end

    // R5: duty position holds between prescaler ticks
    assert_pos_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (dcnt == $past(dcnt)));

    // R7: a zero duty never yields a high comparison
    assert_zero_duty_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty_l == '0) |-> !above);

    // R8: shadow values stay fixed inside a running window
    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> ($stable(duty_l) && $stable(div_l)));

    // R9: entering the running mode begins at position zero
    assert_fresh_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (dcnt == '0));

endmodule

// File: rtl/duty_pwm.sv
module duty_pwm
    import pwm_pkg::*;
#(
    parameter int DIV_W  = 4,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [DUTY_W-1:0] duty,
    input  logic              pwm_en,
    input  logic              force_hi,
    input  logic              pwr_save,
    output logic              pwm_out
);

    pwm_mode_e        mode_q;
    logic             run;
    logic             tick;
    logic             above;
    logic [DIV_W-1:0] div_l;

    pwm_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .force_hi (force_hi),
        .pwm_en   (pwm_en),
        .pwr_save (pwr_save),
        .mode_q   (mode_q),
        .run      (run)
    );

    pwm_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div_l (div_l),
        .tick  (tick)
    );

    pwm_period_ctr #(.DIV_W(DIV_W), .DUTY_W(DUTY_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .duty_in (duty),
        .div_in  (div_sel),
        .div_l   (div_l),
        .above   (above)
    );

    // pin driver selected by mode
    always_comb begin
        unique case (mode_q)
            MODE_HIGH: pwm_out = 1'b1;
            MODE_RUN:  pwm_out = above;
            default:   pwm_out = 1'b0;
        endcase
    end

    // R2: force-high wins over every other control
    assert_force_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(force_hi)) |-> pwm_out);

    // R3: disabled and unforced gives a low pin
    assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(force_hi) && !$past(pwm_en)) |-> !pwm_out);

    // R4: power save silences the modulation
    assert_sleep_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(force_hi) && $past(pwr_save)) |-> !pwm_out);

endmodule

// File: tb/duty_pwm_bench.sv
module duty_pwm_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 4;
    localparam int DUTY_W     = 8;
    localparam int POSITIONS  = 1 << DUTY_W;

    logic              clk;
    logic              rst_n;
    logic [DIV_W-1:0]  div_sel;
    logic [DUTY_W-1:0] duty;
    logic              pwm_en;
    logic              force_hi;
    logic              pwr_save;
    logic              pwm_out;

    int    errors = 0;
    int    checks = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // behavioural reference: mode 0 low, 1 high, 2 running
    int m_mode = 0;
    int m_pre  = 0;
    int m_pos  = 0;
    int m_duty = 0;
    int m_div  = 0;

    duty_pwm #(.DIV_W(DIV_W), .DUTY_W(DUTY_W)) u_duty_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (div_sel),
        .duty     (duty),
        .pwm_en   (pwm_en),
        .force_hi (force_hi),
        .pwr_save (pwr_save),
        .pwm_out  (pwm_out)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic model_step();
        if (!rst_n) begin
            m_mode = 0; m_pre = 0; m_pos = 0; m_duty = 0; m_div = 0;
        end else begin
            if (m_mode == 2) begin
                if (m_pre == (1 << m_div) - 1) begin
                    m_pre = 0;
                    if (m_pos == POSITIONS - 1) begin
                        m_pos  = 0;
                        m_duty = int'(duty);
                        m_div  = int'(div_sel);
                    end else begin
                        m_pos++;
                    end
                end else begin
                    m_pre++;
                end
            end else begin
                m_pre = 0; m_pos = 0;
                m_duty = int'(duty);
                m_div  = int'(div_sel);
            end
            if (force_hi)                m_mode = 1;
            else if (pwm_en && !pwr_save) m_mode = 2;
            else                          m_mode = 0;
        end
    endtask

    task automatic check_out();
        logic exp;
        exp = (m_mode == 1) ? 1'b1 : (m_mode == 2) ? (m_pos < m_duty) : 1'b0;
        checks++;
        if (pwm_out !== exp) begin
            errors++;
            $display("FAIL %s: pwm_out=%0b expected %0b (pos %0d duty %0d)",
                     cur_req, pwm_out, exp, m_pos, m_duty);
        end
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            check_out();
        end
    endtask

    initial begin
        rst_n = 1'b0; div_sel = '0; duty = 8'd64;
        pwm_en = 1'b1; force_hi = 1'b0; pwr_save = 1'b0;
        @(negedge clk);
        cur_req = "R1";                          // reset state, even with enable set
        check_out();
        run_cycles(4);
        rst_n = 1'b1;
        pwm_en = 1'b0;
        run_cycles(2);

        cur_req = "R3";                          // disabled, unforced
        run_cycles(10);

        cur_req = "R2";                          // forced high in every combination
        force_hi = 1'b1; run_cycles(5);
        pwm_en = 1'b1; run_cycles(5);
        pwr_save = 1'b1; run_cycles(5);

        cur_req = "R4";                          // power save with enable set
        force_hi = 1'b0; run_cycles(10);
        pwr_save = 1'b0;

        cur_req = "R6";                          // m=0, n=64
        div_sel = 4'd0; duty = 8'd64;
        run_cycles(300);

        cur_req = "R8";                          // mid-window change of duty and divide
        duty = 8'd200; div_sel = 4'd1;
        run_cycles(1300);

        cur_req = "R7";                          // zero duty reaching boundary
        duty = 8'd0; div_sel = 4'd0;
        run_cycles(800);
        duty = 8'd255;                           // full duty
        run_cycles(600);

        cur_req = "R4";                          // power save pulse mid-window
        duty = 8'd100;
        run_cycles(130);
        pwr_save = 1'b1; run_cycles(20);

        cur_req = "R9";                          // restart is a fresh window
        pwr_save = 1'b0; duty = 8'd30; div_sel = 4'd1;
        run_cycles(150);
        pwm_en = 1'b0; run_cycles(3);
        pwm_en = 1'b1; duty = 8'd90; run_cycles(600);
        force_hi = 1'b1; run_cycles(4);
        force_hi = 1'b0; duty = 8'd7; run_cycles(300);

        cur_req = "R5";                          // m=2 step length, n=1
        pwm_en = 1'b0; run_cycles(2);
        pwm_en = 1'b1; div_sel = 4'd2; duty = 8'd1;
        run_cycles(2100);

        cur_req = "R5";                          // m=3, n=128, one window
        pwm_en = 1'b0; run_cycles(2);
        pwm_en = 1'b1; div_sel = 4'd3; duty = 8'd128;
        run_cycles(2100);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule